// File: doc/BRIEF.md
# Prescaled Down-Counting Timer

This block is a byte-wide timer peripheral for a simple register bus. A fixed front divider turns the system clock into one tick every 12 clocks. Each tick steps a 7-bit prescaler that counts down. A 3-bit select field picks where the 8-bit down counter takes its clock from. The counter can step on every tick. It can also step on the rising edges of one prescaler bit, chosen from bit 0 to bit 6, which divides by 2 up to 128. The longest interval between two zero events is therefore 2^15 ticks.

Software reads and writes the counter and the control/status register. It can read the prescaler, and it can load it while the prescaler runs. When the counter reaches zero by counting down, a sticky zero flag is set. The interrupt request is driven while both that flag and the enable bit are set. Writes take effect at the clock edge that samples them, and reads are combinational from the address.

Top module: `tick_timer`

## Requirements
- R1: After reset, the counter reads FFh, the prescaler reads 7Fh, the control register reads 00h and the interrupt request is low.
- R2: While the run bit is set, the prescaler decrements by one every 12th clock and wraps from 00h to 7Fh. Every 12th clock is counted from the release of reset, and the front divider runs regardless of the run bit.
- R3: While the run bit is clear, the prescaler reads 7Fh, bus writes to the prescaler have no effect, and the counter changes only through a bus write to it.
- R4: While the run bit is set, a bus write to address D2h loads the low 7 data bits into the prescaler, and this takes priority over that cycle's tick.
- R5: With select value 0 the counter decrements on every prescaler tick. With select value k (1..7) it decrements only when a tick-driven prescaler decrement takes bit k-1 from 0 to 1. Bus loads of the prescaler never step the counter.
- R6: The counter at address D3h is readable and writable. A write in the same cycle as a decrement wins.
- R7: A decrement from 00h wraps the counter to FFh, and counting continues.
- R8: A decrement from 01h to 00h sets the zero flag (bit 7 of the control register at D4h). The flag stays set until a control write has 0 in bit 7. A write of 1 in bit 7 leaves it unchanged, and a set in the same cycle wins over a clear.
- R9: The interrupt request is high exactly while the zero flag and the enable bit (bit 6 of D4h) are both set.
- R10: Control register bits 6..0 are stored as written and read back: bit 6 enable, bits 5-4 spare storage, bit 3 run, bits 2-0 tap select.
- R11: Reads from any address other than D2h, D3h and D4h return 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 8 | Register address for both read and write |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| irq | output | 1 | Interrupt request |

## Verification
A bus write is seen on bus_rdata right after the clock edge that samples it, so the bench checks every register value at the next falling edge. A prescaler step, the counter decrement it may cause, the zero flag and the interrupt request all change at that same edge, with no further pipeline stage. The reference model therefore advances once per rising edge. It is compared at each falling edge on whichever address is being driven, and on irq. Runs at every select value and a long pseudo-random phase of bus writes place counter writes on the same cycles as decrements and zero events.

// File: rtl/tt_pkg.sv
`timescale 1ns/1ps
package tt_pkg;

    // control/status register layout (bit positions fixed by software)
    typedef struct packed {
        logic       zf;     // bit 7: counter reached zero
        logic       ie;     // bit 6: interrupt enable
        logic [1:0] spare;  // bits 5-4: plain storage
        logic       run;    // bit 3: prescaler run
        logic [2:0] sel;    // bits 2-0: tap select
    } ctl_t;

    localparam logic [7:0] ADDR_PSC_DEF = 8'hD2;
    localparam logic [7:0] ADDR_CNT_DEF = 8'hD3;
    localparam logic [7:0] ADDR_CTL_DEF = 8'hD4;

endpackage

// File: rtl/tt_frontdiv.sv
`timescale 1ns/1ps
module tt_frontdiv #(
    parameter int DIV = 12
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int W = (DIV > 1) ? $clog2(DIV) : 1;

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = (cnt_q == W'(DIV - 1));
        cnt_d = tick ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/tt_prescale.sv
`timescale 1ns/1ps
module tt_prescale #(
    parameter int PW = 7
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        tick,
    input  logic                        run,
    input  logic                        ld,
    input  logic [PW-1:0]               ld_val,
    input  logic [$clog2(PW+1)-1:0]     sel,
    output logic [PW-1:0]               psc,
    output logic                        adv
);
    localparam int SW = $clog2(PW + 1);

    logic [PW-1:0] psc_d, psc_q;
    logic [PW-1:0] step;
    logic [PW:0]   taps;   // taps[0]: raw tick, taps[k]: rising edge of bit k-1

    always_comb begin
        step  = psc_q - 1'b1;
        taps  = {step & ~psc_q, 1'b1};
        psc_d = psc_q;
        adv   = 1'b0;
        if (!run) begin
            psc_d = '1;
        end else if (ld) begin
            psc_d = ld_val;
        end else if (tick) begin
            psc_d = step;
            if (sel <= SW'(PW)) adv = taps[sel];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) psc_q <= '1;
        else        psc_q <= psc_d;
    end

    assign psc = psc_q;
endmodule

// File: rtl/tick_timer.sv
`timescale 1ns/1ps
module tick_timer
    import tt_pkg::*;
#(
    parameter int         DIV      = 12,
    parameter int         PW       = 7,
    parameter int         DW       = 8,
    parameter int         AW       = 8,
    parameter logic [7:0] ADDR_PSC = ADDR_PSC_DEF,
    parameter logic [7:0] ADDR_CNT = ADDR_CNT_DEF,
    parameter logic [7:0] ADDR_CTL = ADDR_CTL_DEF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_wr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          irq
);
    localparam int SW = $clog2(PW + 1);

    typedef struct packed {
        logic [DW-1:0] cnt;
        ctl_t          ctl;
    } state_t;

    state_t        st_d, st_q;
    logic          tick, adv;
    logic [PW-1:0] psc_val;
    logic          wr_psc, wr_cnt, wr_ctl;

    assign wr_psc = bus_wr && (bus_addr == AW'(ADDR_PSC));
    assign wr_cnt = bus_wr && (bus_addr == AW'(ADDR_CNT));
    assign wr_ctl = bus_wr && (bus_addr == AW'(ADDR_CTL));

    tt_frontdiv #(.DIV(DIV)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    tt_prescale #(.PW(PW)) u_psc (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .run    (st_q.ctl.run),
        .ld     (wr_psc),
        .ld_val (bus_wdata[PW-1:0]),
        .sel    (SW'(st_q.ctl.sel)),
        .psc    (psc_val),
        .adv    (adv)
    );

    always_comb begin
        st_d = st_q;
        // counter: bus write beats a decrement
        if (wr_cnt)   st_d.cnt = bus_wdata;
        else if (adv) st_d.cnt = st_q.cnt - 1'b1;
        // control: bits 6..0 stored, bit 7 may only be cleared
        if (wr_ctl) begin
            st_d.ctl.ie    = bus_wdata[6];
            st_d.ctl.spare = bus_wdata[5:4];
            st_d.ctl.run   = bus_wdata[3];
            st_d.ctl.sel   = bus_wdata[2:0];
            st_d.ctl.zf    = st_q.ctl.zf & bus_wdata[7];
        end
        // reaching zero by decrement sets the flag, over any clear
        if (!wr_cnt && adv && (st_q.cnt == DW'(1))) st_d.ctl.zf = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt <= '1;
            st_q.ctl <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        if (bus_addr == AW'(ADDR_PSC))      bus_rdata = DW'(psc_val);
        else if (bus_addr == AW'(ADDR_CNT)) bus_rdata = st_q.cnt;
        else if (bus_addr == AW'(ADDR_CTL)) bus_rdata = DW'(st_q.ctl);
        else                                bus_rdata = '0;
    end

    assign irq = st_q.ctl.zf & st_q.ctl.ie;
endmodule

// File: rtl/tt_checker.sv
`timescale 1ns/1ps
module tt_checker #(
    parameter int         PW       = 7,
    parameter int         DW       = 8,
    parameter int         AW       = 8,
    parameter logic [7:0] ADDR_PSC = 8'hD2,
    parameter logic [7:0] ADDR_CNT = 8'hD3,
    parameter logic [7:0] ADDR_CTL = 8'hD4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_wr,
    input logic [AW-1:0] bus_addr,
    input logic          irq,
    input logic          run,
    input logic          zf,
    input logic [DW-1:0] cnt,
    input logic [PW-1:0] psc
);
    logic wr_psc, wr_cnt, wr_ctl;
    assign wr_psc = bus_wr && (bus_addr == AW'(ADDR_PSC));
    assign wr_cnt = bus_wr && (bus_addr == AW'(ADDR_CNT));
    assign wr_ctl = bus_wr && (bus_addr == AW'(ADDR_CTL));

    assert_psc_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (psc == '1));

    assert_cnt_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !wr_cnt) |=> $stable(cnt));

    assert_psc_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !wr_psc && !wr_ctl) |=>
            ((psc == $past(psc)) || (psc == PW'($past(psc) - 1'b1))));

    assert_zf_at_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(zf) |-> (cnt == '0));

    assert_irq_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(wr_ctl));
endmodule

bind tick_timer tt_checker #(
    .PW(PW), .DW(DW), .AW(AW),
    .ADDR_PSC(ADDR_PSC), .ADDR_CNT(ADDR_CNT), .ADDR_CTL(ADDR_CTL)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .irq      (irq),
    .run      (st_q.ctl.run),
    .zf       (st_q.ctl.zf),
    .cnt      (st_q.cnt),
    .psc      (psc_val)
);

// File: tb/sim_tick_timer.sv
`timescale 1ns/1ps
module sim_tick_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_addr = 8'hD3;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       irq;

    always #2 clk = ~clk;   // 250 MHz

    tick_timer u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    // behavioural reference state
    int m_div, m_psc, m_cnt, m_zf, m_ie, m_spare, m_run, m_sel;
    int vectors = 0, misses = 0, cycles = 0;
    string phase = "R1";
    bit done = 0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_div = 0; m_psc = 127; m_cnt = 255;
            m_zf = 0; m_ie = 0; m_spare = 0; m_run = 0; m_sel = 0;
        end else begin
            bit tk, adv, setz;
            int npsc, ncnt, nzf, wd;
            wd   = int'(bus_wdata);
            tk   = (m_div == 11);                    // R2: every 12th clock
            m_div = tk ? 0 : m_div + 1;
            adv  = 0; npsc = m_psc;
            if (m_run == 0) npsc = 127;              // R3
            else if (bus_wr && bus_addr == 8'hD2) npsc = wd & 127;   // R4
            else if (tk) begin
                npsc = (m_psc + 127) % 128;
                if (m_sel == 0) adv = 1;             // R5
                else adv = (((npsc >> (m_sel-1)) & 1) == 1) && (((m_psc >> (m_sel-1)) & 1) == 0);
            end
            ncnt = m_cnt; nzf = m_zf; setz = 0;
            if (bus_wr && bus_addr == 8'hD3) ncnt = wd;            // R6
            else if (adv) begin
                ncnt = (m_cnt + 255) % 256;                          // R7
                setz = (m_cnt == 1);
            end
            if (bus_wr && bus_addr == 8'hD4) begin                   // R10
                m_ie = (wd >> 6) & 1; m_spare = (wd >> 4) & 3;
                m_run = (wd >> 3) & 1; m_sel = wd & 7;
                if (((wd >> 7) & 1) == 0) nzf = 0;                    // R8
            end
            if (setz) nzf = 1;
            m_psc = npsc; m_cnt = ncnt; m_zf = nzf;
        end
    end

    function automatic int model_read(logic [7:0] a);
        case (a)
            8'hD2:   return m_psc;
            8'hD3:   return m_cnt;
            8'hD4:   return (m_zf << 7) | (m_ie << 6) | (m_spare << 4) | (m_run << 3) | m_sel;
            default: return 0;
        endcase
    endfunction

    function automatic string tag_of(logic [7:0] a);
        case (a)
            8'hD2:   return "R2";
            8'hD3:   return "R6";
            8'hD4:   return "R10";
            default: return "R11";
        endcase
    endfunction

    task automatic compare();
        int exp_rd, exp_irq;
        exp_rd  = model_read(bus_addr);
        exp_irq = m_zf & m_ie;                                       // R9
        vectors++;
        if (int'(bus_rdata) != exp_rd) begin
            misses++;
            $display("FAIL %s [%s] addr %h: rdata %h expected %h",
                     tag_of(bus_addr), phase, bus_addr, bus_rdata, exp_rd[7:0]);
        end
        vectors++;
        if (int'(irq) != exp_irq) begin
            misses++;
            $display("FAIL R9 [%s]: irq %0d expected %0d", phase, irq, exp_irq);
        end
    endtask

    task automatic cyc(input bit wr, input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        compare();
        bus_wr = wr; bus_addr = a; bus_wdata = d;
    endtask

    task automatic idle(input logic [7:0] a, input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, a, 8'h00);
    endtask

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000 && !done) begin
            misses++;
            $display("FAIL watchdog: run did not finish, actual %0d cycles expected < 190000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        // R1: reset values on every register
        phase = "R1";
        cyc(0, 8'hD2, 0); cyc(0, 8'hD3, 0); cyc(0, 8'hD4, 0); cyc(0, 8'hD3, 0);
        @(negedge clk); rst_n = 1'b1;

        // R10: storage bits, run stays clear
        phase = "R10";
        cyc(1, 8'hD4, 8'h37); idle(8'hD4, 3);
        // R3: stopped prescaler ignores loads, counter holds
        phase = "R3";
        cyc(1, 8'hD2, 8'h12); idle(8'hD2, 3);
        cyc(1, 8'hD3, 8'h05); idle(8'hD3, 40);
        // R2 / R5: run with tap 0, counter steps each tick, reaches zero (R8)
        phase = "R2";
        cyc(1, 8'hD4, 8'h08); idle(8'hD2, 30); idle(8'hD3, 40); idle(8'hD4, 10);
        // R9: enable with flag kept (bit 7 written as 1)
        phase = "R9";
        cyc(1, 8'hD4, 8'hC8); idle(8'hD4, 5);
        // R7: counter wraps below zero
        phase = "R7";
        idle(8'hD3, 40);
        // R8: write 0 in bit 7 clears flag and drops irq
        phase = "R8";
        cyc(1, 8'hD4, 8'h48); idle(8'hD4, 4);
        // R4: load the running prescaler
        phase = "R4";
        cyc(1, 8'hD2, 8'h05); idle(8'hD2, 80);
        // R5: tap selects 1, 3 and 7
        phase = "R5";
        cyc(1, 8'hD4, 8'h49); cyc(1, 8'hD3, 8'h10); idle(8'hD3, 300);
        cyc(1, 8'hD4, 8'h4B); cyc(1, 8'hD3, 8'h03); idle(8'hD3, 600); idle(8'hD4, 100);
        cyc(1, 8'hD4, 8'h4F); cyc(1, 8'hD3, 8'h02); idle(8'hD3, 2000); idle(8'hD4, 2000);
        // R6: pseudo-random writes, counter writes collide with decrements
        phase = "R6";
        cyc(1, 8'hD4, 8'h48);
        lfsr = 16'hACE1;
        for (int i = 0; i < 20000; i++) begin
            logic [7:0] a, d;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            case (lfsr[2:0])
                3'd0, 3'd1: a = 8'hD2;
                3'd2, 3'd3, 3'd4: a = 8'hD3;
                3'd5, 3'd6: a = 8'hD4;
                default: a = 8'hD5;
            endcase
            d = lfsr[15:8];
            if (a == 8'hD4) d[3] = (lfsr[7:4] != 4'h0);   // keep mostly running
            if (a == 8'hD3 && lfsr[5]) d = 8'h01;          // frequent near-zero loads
            cyc(lfsr[3] & lfsr[6] & lfsr[9], a, d);
        end
        // R11: unmapped addresses read zero
        phase = "R11";
        cyc(0, 8'h00, 0); cyc(0, 8'hD5, 0); cyc(0, 8'hFF, 0); cyc(0, 8'hD1, 0);
        cyc(0, 8'hD3, 0);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule